// File: doc/BRIEF.md
# Single-Word Serial Peripheral Master

This block moves one word at a time over a four-wire SPI link, acting as the master. It runs from the system clock. The serial clock, the word length and the setup time between selecting the slave and the first clock edge all come from configuration inputs. A one-cycle `start` request captures that configuration together with the transmit word. The block then pulls chip select low and waits out the setup time. Next it exchanges the chosen number of bits, most significant first. Finally it releases chip select, places the received bits on `rx_word` and pulses `done`.

Two configurations are illegal: a zero divider, and a length code above 8. A start request with either is refused. The block answers with a one-cycle `err` pulse and leaves the serial lines idle. The divider resets to zero in the surrounding register file, so software has to load a legal value before the first transfer.

Top module: `spi_word_master`

## Requirements
- R1: The serial clock period P, in system clock cycles, equals `cfg_div` for values 2 to 255. A value of 1 gives P = 2. Each period holds `sck` high for floor(P/2) cycles and low for the rest.
- R2: A start with `cfg_div` = 0 is refused. `err` is high for exactly one cycle, `cs_n` stays high and `busy` stays low.
- R3: A length code c from 0 to 8 transfers 8 + c bits, so `sck` makes exactly 8 + c rising edges while `cs_n` is low.
- R4: A start with a length code from 9 to 15 is refused in the same way as in R2.
- R5: When `cfg_lead` is 0, the first rising edge of `sck` comes floor(P/2) cycles after `cs_n` falls.
- R6: When `cfg_lead` is nonzero, the first rising edge of `sck` comes `cfg_lead` cycles after `cs_n` falls.
- R7: `sck` is low whenever `cs_n` is high. `mosi` changes only on a falling edge of `sck` or when `cs_n` changes. For an n-bit transfer the bits sent are `tx_word[15]` down to `tx_word[16-n]`, in that order. `miso` is sampled as `sck` rises.
- R8: The n received bits sit right-aligned in `rx_word`, with the first bit received at bit n-1 and bits 15 down to n at zero.
- R9: `cs_n` returns high floor(P/2) cycles after the last falling edge of `sck`. `done` is high for one cycle, in the same cycle that `cs_n` rises. `busy` is high from the cycle `cs_n` falls until the cycle it rises.
- R10: Configuration changes made while `busy` is high do not affect the transfer in progress.
- R11: A start request made while `busy` is high is ignored. It neither starts a second transfer nor raises `err`.
- R12: After reset, `cs_n` is 1 and `sck`, `mosi`, `busy`, `done`, `err` and `rx_word` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | 8 | Serial clock divider, 1 to 255 legal |
| cfg_len | input | 4 | Word length code, bits = 8 + code, codes 0 to 8 legal |
| cfg_lead | input | 8 | Chip-select-to-clock setup in cycles, 0 means half a serial period |
| start | input | 1 | Transfer request, sampled when idle |
| tx_word | input | 16 | Transmit word, left-aligned |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at end of transfer |
| err | output | 1 | One-cycle pulse on a refused start |
| rx_word | output | 16 | Received word, right-aligned |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
Some properties are checked by assertions on every cycle:
- `sck` stays low while the slave is deselected, and `mosi` moves only at a falling clock edge or a chip-select change.
- `done` lasts one cycle and coincides with chip-select release, and `busy` covers the whole selected window.
- A refused start never selects the slave, and a new selection only follows an idle cycle.

Other behaviour only the bench scenarios can show, because it depends on configuration values and on the data exchanged:
- the serial period and the setup and hold timings measured in cycles;
- the exact edge count for each length code;
- the bit order on both data lines and the zero upper bits of the received word;
- the latching of configuration at start.

// File: rtl/spi_word_master.sv
module spi_word_master #(
  parameter int DIV_W  = 8,
  parameter int LEAD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [3:0]        cfg_len,
  input  logic [LEAD_W-1:0] cfg_lead,
  input  logic              start,
  input  logic [15:0]       tx_word,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [15:0]       rx_word,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);
  localparam int CNT_W    = (DIV_W > LEAD_W) ? DIV_W : LEAD_W;
  localparam int CODE_MAX = 8;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_HIGH, S_LOW, S_TAIL} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic [DIV_W-1:0] div_q;
  logic [4:0]       nbits_q, bitcnt;
  logic [15:0]      txsh, rxsh;

  function automatic logic [CNT_W-1:0] period_of(input logic [DIV_W-1:0] d);
    period_of = (d < DIV_W'(2)) ? CNT_W'(2) : CNT_W'(d);
  endfunction

  function automatic logic [CNT_W-1:0] half_of(input logic [DIV_W-1:0] d);
    half_of = period_of(d) >> 1;
  endfunction

  wire              cfg_ok   = (cfg_div != '0) && (cfg_len <= 4'(CODE_MAX));
  wire [CNT_W-1:0]  lead_cyc = (cfg_lead == '0) ? half_of(cfg_div) : CNT_W'(cfg_lead);
  wire [CNT_W-1:0]  hi_c     = half_of(div_q);
  wire [CNT_W-1:0]  lo_c     = period_of(div_q) - hi_c;
  wire              expire   = (cnt == CNT_W'(1));
  wire              last_bit = (bitcnt == nbits_q - 5'd1);

  assign mosi = txsh[15];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      div_q   <= '0;
      nbits_q <= '0;
      bitcnt  <= '0;
      txsh    <= '0;
      rxsh    <= '0;
      rx_word <= '0;
      sck     <= 1'b0;
      cs_n    <= 1'b1;
      busy    <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        S_IDLE:
          if (start) begin
            if (cfg_ok) begin
              div_q   <= cfg_div;
              nbits_q <= 5'd8 + {1'b0, cfg_len};
              bitcnt  <= '0;
              txsh    <= tx_word;
              rxsh    <= '0;
              cnt     <= lead_cyc;
              cs_n    <= 1'b0;
              busy    <= 1'b1;
              state   <= S_LEAD;
            end else begin
              err <= 1'b1;
            end
          end
        S_LEAD, S_LOW:
          if (expire) begin
            sck   <= 1'b1;
            rxsh  <= {rxsh[14:0], miso};
            cnt   <= hi_c;
            state <= S_HIGH;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        S_HIGH:
          if (expire) begin
            sck <= 1'b0;
            if (last_bit) begin
              cnt   <= hi_c;
              state <= S_TAIL;
            end else begin
              txsh   <= {txsh[14:0], 1'b0};
              bitcnt <= bitcnt + 5'd1;
              cnt    <= lo_c;
              state  <= S_LOW;
            end
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        S_TAIL:
          if (expire) begin
            cs_n    <= 1'b1;
            busy    <= 1'b0;
            done    <= 1'b1;
            rx_word <= rxsh;
            txsh    <= '0;
            state   <= S_IDLE;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_word_master_chk.sv
module spi_word_master_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic err,
  input logic sck,
  input logic mosi,
  input logic cs_n
);
  a_r7_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  a_r7_mosi_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi) |-> ($fell(sck) || !$stable(cs_n)));

  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(cs_n));

  a_r9_busy_covers_select: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  a_r2_err_no_select: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (cs_n && !busy));

  a_r11_select_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(!busy));
endmodule

bind spi_word_master spi_word_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .sck(sck), .mosi(mosi), .cs_n(cs_n)
);

// File: tb/spi_word_master_test.sv
module spi_word_master_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [7:0]  cfg_div = '0, cfg_lead = '0;
  logic [3:0]  cfg_len = '0;
  logic        start = 1'b0;
  logic [15:0] tx_word = '0;
  logic        miso = 1'b0;
  logic        busy, done, err, sck, mosi, cs_n;
  logic [15:0] rx_word;

  spi_word_master uut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_len(cfg_len),
    .cfg_lead(cfg_lead), .start(start), .tx_word(tx_word), .busy(busy),
    .done(done), .err(err), .rx_word(rx_word), .sck(sck), .mosi(mosi),
    .miso(miso), .cs_n(cs_n)
  );

  int tests = 0, fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // slave model and monitor, sampled mid-cycle
  int cur_n = 8, exp_per = 2, sl_idx = 0;
  logic [15:0] cur_sd = '0, mosi_cap = '0;
  int cs_falls = 0, rises = 0, per_bad = 0, done_w = 0;
  int cs_fall_c = 0, cs_rise_c = 0, first_rise_c = 0, prev_rise_c = 0, last_fall_c = 0, done_c = 0;
  logic prev_cs = 1'b1, prev_sck = 1'b0;

  always @(negedge clk) begin
    if (prev_cs && !cs_n) begin
      cs_falls++; cs_fall_c = cyc; rises = 0; mosi_cap = '0; per_bad = 0; done_w = 0;
      miso = cur_sd[cur_n-1]; sl_idx = cur_n - 2;
    end
    if (!prev_cs && cs_n) cs_rise_c = cyc;
    if (!prev_sck && sck) begin
      if (rises == 0) first_rise_c = cyc;
      else if (cyc - prev_rise_c != exp_per) per_bad++;
      prev_rise_c = cyc; rises++;
      mosi_cap = {mosi_cap[14:0], mosi};
    end
    if (prev_sck && !sck) begin
      last_fall_c = cyc;
      if (sl_idx >= 0) begin miso = cur_sd[sl_idx]; sl_idx--; end
    end
    if (done) begin done_w++; done_c = cyc; end
    prev_cs = cs_n; prev_sck = sck;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  // {div, len, lead, tx, slave data}
  localparam logic [55:0] VEC [0:5] = '{
    {8'd4, 8'd0, 8'd0, 16'hA500, 16'h003C},
    {8'd5, 8'd8, 8'd3, 16'h1234, 16'hBEEF},
    {8'd1, 8'd4, 8'd0, 16'hFFF0, 16'h0ABC},
    {8'd2, 8'd1, 8'd7, 16'h8080, 16'hFE5A},
    {8'd7, 8'd5, 8'd1, 16'h5A5A, 16'hFFFF},
    {8'd3, 8'd2, 8'd0, 16'hC3C0, 16'h0155}
  };

  task automatic xfer(input logic [7:0] d, input logic [3:0] c, input logic [7:0] ld,
                      input logic [15:0] tx, input logic [15:0] sd, input bit disturb);
    int p, h, n, lexp, falls0, w;
    p = (d < 2) ? 2 : int'(d);
    h = p / 2;
    n = 8 + int'(c);
    lexp = (ld == 0) ? h : int'(ld);
    exp_per = p; cur_n = n; cur_sd = sd;
    cfg_div = d; cfg_len = c; cfg_lead = ld; tx_word = tx; start = 1'b1;
    step();
    start = 1'b0;
    falls0 = cs_falls;
    if (disturb) begin
      cfg_div = 8'd3; cfg_len = 4'd8; cfg_lead = 8'd9; tx_word = 16'h0000;
      step(); step();
      start = 1'b1; step(); start = 1'b0;
      chk(err == 1'b0, "R11 err on start while busy", 32'(err), 0);
    end
    w = 0;
    while (done_w == 0 && w < 20000) begin step(); w++; end
    chk(rises == n, "R3 rising edge count", rises, n);
    chk(first_rise_c - cs_fall_c == lexp, (ld == 0) ? "R5 half-period setup" : "R6 programmed setup",
        first_rise_c - cs_fall_c, lexp);
    chk(per_bad == 0, "R1 serial period", per_bad, 0);
    chk(mosi_cap == (tx >> (16 - n)), "R7 bits sent msb first", mosi_cap, tx >> (16 - n));
    chk(rx_word == (sd & 16'((1 << n) - 1)), "R8 right-aligned receive", rx_word, sd & 16'((1 << n) - 1));
    chk(cs_rise_c - last_fall_c == h, "R9 hold after last edge", cs_rise_c - last_fall_c, h);
    chk(done_c == cs_rise_c && done_w == 1, "R9 done pulse at release", done_w, 1);
    chk(busy == 1'b0 && cs_n == 1'b1, "R9 busy clears with release", {busy, cs_n}, 1);
    if (disturb) begin
      repeat (20) step();
      chk(cs_falls == falls0 && cs_n == 1'b1, "R11 no second transfer", cs_falls - falls0, 0);
      chk(rises == n && per_bad == 0, "R10 config latched at start", rises, n);
    end
    repeat (3) step();
  endtask

  task automatic reject(input logic [7:0] d, input logic [3:0] c, input string tag);
    int f0;
    f0 = cs_falls;
    cfg_div = d; cfg_len = c; cfg_lead = 8'd0; start = 1'b1;
    step();
    start = 1'b0;
    chk(err == 1'b1, tag, 32'(err), 1);
    step();
    chk(err == 1'b0, tag, 32'(err), 0);
    repeat (10) step();
    chk(cs_falls == f0 && cs_n && !busy && !sck, tag, cs_falls - f0, 0);
  endtask

  initial begin
    repeat (3) step();
    chk(cs_n == 1'b1 && sck == 1'b0 && mosi == 1'b0, "R12 reset serial lines", {cs_n, sck, mosi}, 3'b100);
    chk(busy == 1'b0 && done == 1'b0 && err == 1'b0 && rx_word == 16'h0, "R12 reset status",
        {busy, done, err, rx_word}, 0);
    rst_n = 1'b1;
    repeat (2) step();
    for (int i = 0; i < 6; i++)
      xfer(VEC[i][55:48], VEC[i][43:40], VEC[i][39:32], VEC[i][31:16], VEC[i][15:0], 1'b0);
    xfer(8'd255, 4'd0, 8'd255, 16'h6900, 16'h0096, 1'b0);
    xfer(8'd6, 4'd0, 8'd2, 16'hB700, 16'h00C8, 1'b1);
    reject(8'd0, 4'd0, "R2 zero divider refused");
    reject(8'd4, 4'd9, "R4 length code 9 refused");
    reject(8'd4, 4'd15, "R4 length code 15 refused");
    xfer(8'd2, 4'd8, 8'd0, 16'h8001, 16'h8001, 1'b0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule